// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a watchdog timer that pulls the system into reset unless software services it within a fixed number of bus clocks. Software services it with a bus write of a zero in data bit 0 to one fixed address (0x1FF0 by default). The block only watches the write strobe, address and write data. It has no read-data path, so a read of that address returns whatever the memory array holds there. A static option input turns the watchdog on. The count freezes while the oscillator is stopped. In the wait and halt low-power states the oscillator keeps running, so the count keeps going.

When the count expires, the block drives a reset pulse of fixed length. It also holds the operating-mode value for the chip. The level of the mode-select pin is captured once, at the release of the external reset. That captured value stays in force through every watchdog reset that follows, and the pin is not sampled again until the next external reset.

Top module: `svc_wdog`

## Requirements
- R1: While `cop_en` is 0 the count is held at zero and no reset pulse starts. A pulse is seen only after `cop_en` has been 1 for TIMEOUT counting edges.
- R2: A write (`bus_wr`=1) to address SVC_ADDR (default 0x1FF0) with data bit SVC_BIT (default bit 0) equal to 0 restarts the count. The pulse then starts at the TIMEOUT-th edge after the edge that took the write.
- R3: None of these changes the count: a write to SVC_ADDR with bit 0 equal to 1, a write of 0 to any other address (for example 0x1FF1), or SVC_ADDR on the address bus with `bus_wr`=0 (a read).
- R4: After external reset release, with no service, `wdog_rst` first goes high right after the TIMEOUT-th rising clock edge following the release, and not before.
- R5: `wdog_rst` stays high for exactly PULSE_LEN cycles. The count is held at zero during the pulse and starts again afterwards, so the next unserviced pulse starts TIMEOUT+PULSE_LEN edges after the previous one.
- R6: While `osc_run` is 0 the count holds its value and no pulse starts. Counting resumes from the held value, so each frozen edge delays expiry by one cycle.
- R7: `ext_rst_n` low clears the count and the pulse at once, without waiting for a clock edge. While it is low, `wdog_rst` and `mode_sel` are 0.
- R8: `mode_sel` takes the level of `mode_pin` at the first rising clock edge after `ext_rst_n` goes high.
- R9: A watchdog pulse never recaptures the mode. `mode_sel` keeps its captured value through watchdog resets, whatever the level on `mode_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assert |
| cop_en | input | 1 | Static watchdog enable option |
| osc_run | input | 1 | 1 while the oscillator runs; 0 in stop mode |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (13) | Bus address |
| bus_wdata | input | DATA_W (8) | Bus write data |
| mode_pin | input | 1 | Mode-select pin level |
| wdog_rst | output | 1 | Watchdog reset pulse, active high |
| mode_sel | output | 1 | Mode value captured at the last external reset release |

## Verification
The count cannot be read directly, so a wrong count shows up only as a shifted pulse edge. An extra clear, a missed clear, a frozen edge that still counts, or an off-by-one limit each moves the rising edge of `wdog_rst` by a whole number of cycles. That shift appears at the next expiry, up to TIMEOUT+PULSE_LEN cycles later, which is why every pulse edge is compared against a cycle number predicted in advance. A bad mode latch shows on `mode_sel` one edge after reset release. A wrong recapture shows at the first watchdog pulse that follows a change on the pin.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

   // Per-cycle action selected for the timeout counter
   typedef enum logic [1:0] {
      CNT_HOLD  = 2'd0,
      CNT_CLEAR = 2'd1,
      CNT_STEP  = 2'd2,
      CNT_WRAP  = 2'd3
   } cnt_op_e;

   // Conditions that steer the counter in one cycle
   typedef struct packed {
      logic enabled;
      logic osc_on;
      logic pulsing;
      logic service;
   } cnt_ctl_t;

   function automatic cnt_op_e pick_op(cnt_ctl_t ctl, logic at_limit);
      cnt_op_e op;
      if (!ctl.enabled)     op = CNT_CLEAR;
      else if (ctl.pulsing) op = CNT_CLEAR;
      else if (!ctl.osc_on) op = CNT_HOLD;
      else if (ctl.service) op = CNT_CLEAR;
      else if (at_limit)    op = CNT_WRAP;
      else                  op = CNT_STEP;
      return op;
   endfunction

endpackage

// File: rtl/svc_wdog_wr_decode.sv
module svc_wdog_wr_decode #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR = 13'h1FF0,
   parameter int SVC_BIT = 0
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              service
);
   localparam logic [DATA_W-1:0] BIT_MASK = DATA_W'(1) << SVC_BIT;

   logic addr_hit;
   logic bit_low;

   if (SVC_BIT < 0 || SVC_BIT >= DATA_W) begin : g_bad_bit
      $error("svc_wdog_wr_decode: SVC_BIT out of data range");
   end

   assign addr_hit = (addr == SVC_ADDR);
   assign bit_low  = ((wdata & BIT_MASK) == '0);
   assign service  = wr & addr_hit & bit_low;
endmodule

// File: rtl/svc_wdog_timebase.sv
module svc_wdog_timebase
   import svc_wdog_pkg::*;
#(
   parameter int TIMEOUT = 32768
) (
   input  logic     clk,
   input  logic     rst_n,
   input  cnt_ctl_t ctl,
   output logic     expire
);
   localparam int CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT - 1);

   logic [CNT_W-1:0] cnt_q;
   cnt_op_e          op;

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("svc_wdog_timebase: TIMEOUT must be at least 2");
   end

   assign op     = pick_op(ctl, cnt_q == LIMIT);
   assign expire = (op == CNT_WRAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (op)
            CNT_HOLD:  cnt_q <= cnt_q;
            CNT_CLEAR: cnt_q <= '0;
            CNT_STEP:  cnt_q <= cnt_q + CNT_W'(1);
            CNT_WRAP:  cnt_q <= '0;
            default:   cnt_q <= '0;
         endcase
      end
   end
endmodule

// File: rtl/svc_wdog_pulse.sv
module svc_wdog_pulse #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   if (PULSE_LEN < 1) begin : g_bad_len
      $error("svc_wdog_pulse: PULSE_LEN must be at least 1");
   end else if (PULSE_LEN == 1) begin : g_single
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= start;
      end
      assign active = hit_q;
   end else begin : g_counted
      localparam int PW = $clog2(PULSE_LEN + 1);
      logic [PW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              left_q <= '0;
         else if (start)          left_q <= PW'(PULSE_LEN);
         else if (left_q != '0)   left_q <= left_q - PW'(1);
      end
      assign active = (left_q != '0);
   end
endmodule

// File: rtl/svc_wdog_mode_latch.sv
module svc_wdog_mode_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic mode
);
   logic released_q;
   logic mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         released_q <= 1'b0;
         mode_q     <= 1'b0;
      end else begin
         released_q <= 1'b1;
         if (!released_q) mode_q <= pin;
      end
   end

   assign mode = mode_q;
endmodule

// File: rtl/svc_wdog.sv
module svc_wdog
   import svc_wdog_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR = 13'h1FF0,
   parameter int SVC_BIT = 0,
   parameter int TIMEOUT = 32768,
   parameter int PULSE_LEN = 4
) (
   input  logic              clk,
   input  logic              ext_rst_n,
   input  logic              cop_en,
   input  logic              osc_run,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              mode_pin,
   output logic              wdog_rst,
   output logic              mode_sel
);
   logic     service;
   logic     expire;
   logic     pulsing;
   cnt_ctl_t ctl;

   svc_wdog_wr_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR), .SVC_BIT(SVC_BIT)
   ) u_dec (
      .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .service(service)
   );

   assign ctl = '{enabled: cop_en, osc_on: osc_run, pulsing: pulsing, service: service};

   svc_wdog_timebase #(.TIMEOUT(TIMEOUT)) u_tb (
      .clk(clk), .rst_n(ext_rst_n), .ctl(ctl), .expire(expire)
   );

   svc_wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(ext_rst_n), .start(expire), .active(pulsing)
   );

   svc_wdog_mode_latch u_mode (
      .clk(clk), .rst_n(ext_rst_n), .pin(mode_pin), .mode(mode_sel)
   );

   assign wdog_rst = pulsing;
endmodule

// File: rtl/svc_wdog_chk.sv
module svc_wdog_chk #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR = 13'h1FF0,
   parameter int SVC_BIT = 0,
   parameter int PULSE_LEN = 4
) (
   input logic              clk,
   input logic              ext_rst_n,
   input logic              cop_en,
   input logic              osc_run,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              mode_pin,
   input logic              wdog_rst,
   input logic              mode_sel
);
   localparam int HW = $clog2(PULSE_LEN + 2);
   localparam logic [DATA_W-1:0] BIT_MASK = DATA_W'(1) << SVC_BIT;

   logic [HW-1:0] high_run_q;
   logic          settled_q;
   logic          svc_write;

   assign svc_write = bus_wr && (bus_addr == SVC_ADDR) && ((bus_wdata & BIT_MASK) == '0);

   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) begin
         high_run_q <= '0;
         settled_q  <= 1'b0;
      end else begin
         high_run_q <= wdog_rst ? high_run_q + HW'(1) : '0;
         settled_q  <= 1'b1;
      end
   end

   // R1
   disabled_no_start_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (!cop_en && !wdog_rst) |=> !wdog_rst);

   // R2
   service_no_expire_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (svc_write && cop_en && osc_run && !wdog_rst) |=> !wdog_rst);

   // R5
   pulse_not_long_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      wdog_rst |-> (high_run_q < HW'(PULSE_LEN)));

   // R5
   pulse_full_len_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      $fell(wdog_rst) |-> (high_run_q == HW'(PULSE_LEN)));

   // R6
   frozen_no_start_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (!osc_run && !wdog_rst) |=> !wdog_rst);

   // R9
   mode_held_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
      (settled_q && (mode_pin || !mode_pin)) |=> $stable(mode_sel));
endmodule

bind svc_wdog svc_wdog_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
   .SVC_BIT(SVC_BIT), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk(clk), .ext_rst_n(ext_rst_n), .cop_en(cop_en), .osc_run(osc_run),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .mode_pin(mode_pin), .wdog_rst(wdog_rst), .mode_sel(mode_sel)
);

// File: tb/tb_svc_wdog.sv
module tb_svc_wdog;
   localparam int T = 20;
   localparam int P = 4;
   localparam logic [12:0] SVC = 13'h1FF0;

   logic        clk = 1'b0;
   logic        ext_rst_n, cop_en, osc_run, bus_wr, mode_pin;
   logic [12:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        wdog_rst, mode_sel;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   int exp_q[$];
   int rise_cyc = 0;
   logic prev_rst = 1'b0;

   svc_wdog #(.TIMEOUT(T), .PULSE_LEN(P)) dut (
      .clk(clk), .ext_rst_n(ext_rst_n), .cop_en(cop_en), .osc_run(osc_run),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .mode_pin(mode_pin), .wdog_rst(wdog_rst), .mode_sel(mode_sel)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wait_until(input int target);
      while (cyc < target) @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   // Monitor: compares each pulse edge against the scoreboard queue
   always @(negedge clk) begin
      if (wdog_rst && !prev_rst) begin
         rise_cyc = cyc;
         if (exp_q.size() == 0) chk(1'b0, "R4 unexpected pulse", cyc, -1);
         else begin
            int e;
            e = exp_q.pop_front();
            chk(cyc == e, "R4/R2/R5/R6 pulse start cycle", cyc, e);
         end
      end
      if (!wdog_rst && prev_rst && ext_rst_n)
         chk(cyc - rise_cyc == P, "R5 pulse length", cyc - rise_cyc, P);
      prev_rst = wdog_rst;
   end

   initial begin
      repeat (5000) @(posedge clk);
      chk(1'b0, "watchdog expired", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      int c0, c1, c3, c5, e2, e3;
      bit quiet;
      ext_rst_n = 1'b0; cop_en = 1'b1; osc_run = 1'b1; bus_wr = 1'b0;
      bus_addr = '0; bus_wdata = '0; mode_pin = 1'b0;
      repeat (3) @(negedge clk);
      // R7: reset state
      chk(wdog_rst == 1'b0, "R7 reset wdog_rst", wdog_rst, 0);
      chk(mode_sel == 1'b0, "R7 reset mode_sel", mode_sel, 0);

      // R4/R8: release with pin high
      mode_pin = 1'b1;
      ext_rst_n = 1'b1;
      c0 = cyc;
      exp_q.push_back(c0 + T);
      @(negedge clk);
      chk(mode_sel == 1'b1, "R8 capture at release", mode_sel, 1);
      mode_pin = 1'b0;
      wait_until(c0 + T - 1);
      chk(wdog_rst == 1'b0, "R4 not early", wdog_rst, 0);
      @(negedge clk);
      chk(wdog_rst == 1'b1, "R4 expiry", wdog_rst, 1);
      wait_until(c0 + T + P + 2);
      chk(mode_sel == 1'b1, "R9 mode kept over watchdog reset", mode_sel, 1);

      // R2/R3: service, then writes that must not service
      c1 = cyc;
      bus_wr = 1'b1; bus_addr = SVC; bus_wdata = 8'hFE;
      exp_q.push_back(c1 + 1 + T);
      @(negedge clk); bus_wdata = 8'h01;
      @(negedge clk); bus_addr = 13'h1FF1; bus_wdata = 8'h00;
      @(negedge clk); bus_wr = 1'b0; bus_addr = SVC; bus_wdata = 8'h00;
      @(negedge clk); bus_addr = '0;
      e2 = c1 + 1 + T;
      wait_until(e2 + P + 2);

      // R6: freeze for 7 edges
      c3 = cyc;
      e3 = e2 + P + T + 7;
      exp_q.push_back(e3);
      osc_run = 1'b0;
      repeat (7) @(negedge clk);
      osc_run = 1'b1;
      chk(cyc == c3 + 7, "R6 freeze window", cyc, c3 + 7);

      // R7: external reset in the middle of a pulse
      wait_until(e3 + 2);
      chk(wdog_rst == 1'b1, "R5 pulse still high", wdog_rst, 1);
      ext_rst_n = 1'b0; cop_en = 1'b0; mode_pin = 1'b1;
      #1;
      chk(wdog_rst == 1'b0, "R7 async clear of pulse", wdog_rst, 0);
      chk(mode_sel == 1'b0, "R7 mode cleared in reset", mode_sel, 0);
      @(negedge clk); @(negedge clk);
      ext_rst_n = 1'b1;
      @(negedge clk);
      chk(mode_sel == 1'b1, "R8 recapture at new release", mode_sel, 1);
      mode_pin = 1'b0;

      // R1: disabled, no pulse over three timeouts
      quiet = 1'b1;
      repeat (3 * T) begin
         @(negedge clk);
         if (wdog_rst) quiet = 1'b0;
      end
      chk(quiet, "R1 no pulse while disabled", !quiet, 0);
      cop_en = 1'b1;
      c5 = cyc;
      exp_q.push_back(c5 + T);
      wait_until(c5 + T + P + 2);
      chk(exp_q.size() == 0, "R1 pulse after enable", exp_q.size(), 0);
      chk(mode_sel == 1'b1, "R9 mode kept after second pulse", mode_sel, 1);

      summary();
      $finish;
   end
endmodule